// File: doc/BRIEF.md
# Serial Control Register Interface

This block is a write-only three-wire serial slave that sets the control state of an imaging front end. A host lowers an active-low select line, clocks sixteen data bits in least-significant-bit first, and raises select again. The two lowest bits of the word choose one of four internal registers. The other fourteen bits become that register's new contents. There is no read path.

The select, serial clock and data pins are brought into the system clock domain through two-flop synchronisers. The block then finds their edges there, so the system clock must run at least four times faster than the serial clock. A frame is accepted only when exactly sixteen serial clock rising edges arrive while select is low. It takes effect when select rises. Each accepted frame gives a one-cycle write pulse together with the address that was written. The stored fields drive parallel outputs: gain code, sampling and optical-black polarities, clock-range select, offset-cancel controls, clamp level, output-mode bits, and the reset, offset-calibration, standby and sleep controls. The gain and clamp outputs are saturated to their legal ranges.

Top module: `ctrl_serial_regs`

## Requirements
- R1: The data line is sampled on each serial clock rising edge while select is low. The first bit sampled becomes frame bit 0 and the sixteenth becomes frame bit 15.
- R2: Frame bits 1:0 route the payload. 0 selects the gain register, 1 the control register, 2 the clamp register, and 3 changes no output field.
- R3: A select-low window with fewer than 16 serial clock edges is discarded. All outputs are left as they were and no write pulse is given.
- R4: A select-low window with more than 16 serial clock edges is discarded in the same way.
- R5: The outputs change only after select rises. They keep their old values while bits are shifting, even once all sixteen have arrived.
- R6: Frame bits 12:2 of a gain write hold an 11-bit two's-complement gain code. A stored code below -81 drives the gain output as -81 (0x7AF). Codes from -81 to 1023 pass through unchanged.
- R7: A control write maps frame bits as follows. Bit 2 is sample-pulse inversion, bit 3 optical-black polarity, bit 4 low clock range, bit 5 offset-cancel enable, bits 9:6 the offset code, bit 10 LSB-invert, bit 11 MSB-invert, bit 12 test output, bit 13 run (0 holds the core in reset), bit 14 offset calibration, and bit 15 sleep.
- R8: Frame bits 6:2 of a clamp write hold the clamp code n, meaning a clamp level of 32+n. Codes above 24 drive the output as 24. Clamp-write bits 15:7 are ignored.
- R9: After reset every output field is zero, and the write pulse is low.
- R10: Each accepted frame gives exactly one write pulse, one system clock cycle wide, with wr_addr equal to frame bits 1:0.
- R11: Bit 15 of a gain write sets the standby output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data |
| gain_code | output | 11 | Saturated two's-complement gain code |
| standby | output | 1 | Standby request |
| smp_inv | output | 1 | Sampling pulse inversion |
| ob_inv | output | 1 | Optical-black pulse polarity |
| lowclk_mode | output | 1 | Low clock frequency range |
| ofs_en | output | 1 | CCD offset cancel enable |
| ofs_code | output | 4 | CCD offset code |
| clamp_code | output | 5 | Saturated clamp code |
| out_linv | output | 1 | Invert output LSBs mode |
| out_minv | output | 1 | Invert output MSB mode |
| out_test | output | 1 | Test output mode |
| core_run | output | 1 | 0 holds analog core in reset |
| ofs_cal | output | 1 | Offset calibration mode |
| sleep | output | 1 | Sleep request |
| wr_pulse | output | 1 | One-cycle strobe per accepted frame |
| wr_addr | output | 2 | Register address of the last accepted frame |

## Verification
The bench sends frames of 15 and 17 bits. A receiver that checked for "at least sixteen" would wrongly commit the long frame, and one that committed on the sixteenth edge would commit the short frame's successor or change outputs early. A frame is held with select low after its last bit to catch a design that updates before select rises. Gain codes of -81, -82 and -1024 and clamp codes of 24 and 31 exercise the saturation edges, where a wrong comparison would pass an illegal code or cut off a legal one. A write to address 3 and a clamp word with its upper bits set check that nothing leaks into unrelated fields.

// File: rtl/ctrl_serial_pkg.sv
package ctrl_serial_pkg;
    localparam int FRAME_W   = 16;
    localparam int ADDR_W    = 2;
    localparam int GAIN_W    = 11;
    localparam int CLAMP_W   = 5;
    localparam int OFS_W     = 4;
    localparam int FIELD_LSB = ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_GAIN  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_CLAMP = 2'd2,
        REG_TEST  = 2'd3
    } reg_sel_e;

    // Packed MSB first: maps directly onto frame bits 15:2 of a control write
    typedef struct packed {
        logic             sleep;
        logic             ofs_cal;
        logic             run;
        logic             test;
        logic             minv;
        logic             linv;
        logic [OFS_W-1:0] ofs_code;
        logic             ofs_en;
        logic             lowclk;
        logic             ob_inv;
        logic             smp_inv;
    } ctl_fields_t;
endpackage

// File: rtl/ctrl_pin_sync.sv
module ctrl_pin_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ctrl_frame_rx.sv
module ctrl_frame_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               sd,
    output logic               frame_ok,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               cs_prev;
        logic               sck_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shift;
        logic               ok;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d          = rx_q;
        rx_d.cs_prev  = cs_n;
        rx_d.sck_prev = sck;
        rx_d.ok       = 1'b0;
        if (!cs_n && rx_q.cs_prev) begin
            rx_d.cnt = '0;
        end else if (!cs_n && sck && !rx_q.sck_prev) begin
            rx_d.shift = {sd, rx_q.shift[FRAME_W-1:1]};
            if (rx_q.cnt != CNT_OVER) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
        if (cs_n && !rx_q.cs_prev && (rx_q.cnt == CNT_FULL)) begin
            rx_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{cs_prev: 1'b1, sck_prev: 1'b0, cnt: '0, shift: '0, ok: 1'b0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign frame_ok = rx_q.ok;
    assign frame    = rx_q.shift;
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import ctrl_serial_pkg::*;
#(
    parameter int GAIN_MIN  = -81,
    parameter int CLAMP_MAX = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_ok,
    input  logic [FRAME_W-1:0]    frame,
    output logic [GAIN_W-1:0]     gain_out,
    output logic                  stby_out,
    output ctl_fields_t           ctl_out,
    output logic [CLAMP_W-1:0]    clamp_out,
    output logic                  pulse_out,
    output logic [ADDR_W-1:0]     addr_out
);
    localparam logic signed [GAIN_W-1:0] GAIN_FLOOR = GAIN_W'(GAIN_MIN);
    localparam logic [CLAMP_W-1:0]       CLAMP_TOP  = CLAMP_W'(CLAMP_MAX);
    localparam int CTL_W = $bits(ctl_fields_t);

    typedef struct packed {
        logic                stby;
        logic [GAIN_W-1:0]   gain;
        ctl_fields_t         ctl;
        logic [CLAMP_W-1:0]  clamp;
        logic                pulse;
        logic [ADDR_W-1:0]   addr;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d       = bk_q;
        bk_d.pulse = 1'b0;
        if (frame_ok) begin
            bk_d.pulse = 1'b1;
            bk_d.addr  = frame[ADDR_W-1:0];
            case (reg_sel_e'(frame[ADDR_W-1:0]))
                REG_GAIN: begin
                    bk_d.gain = frame[FIELD_LSB +: GAIN_W];
                    bk_d.stby = frame[FRAME_W-1];
                end
                REG_CTRL:  bk_d.ctl   = ctl_fields_t'(frame[FIELD_LSB +: CTL_W]);
                REG_CLAMP: bk_d.clamp = frame[FIELD_LSB +: CLAMP_W];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    always_comb begin
        gain_out  = ($signed(bk_q.gain) < GAIN_FLOOR) ? GAIN_FLOOR : bk_q.gain;
        clamp_out = (bk_q.clamp > CLAMP_TOP) ? CLAMP_TOP : bk_q.clamp;
    end

    assign stby_out  = bk_q.stby;
    assign ctl_out   = bk_q.ctl;
    assign pulse_out = bk_q.pulse;
    assign addr_out  = bk_q.addr;
endmodule

// File: rtl/ctrl_serial_regs.sv
module ctrl_serial_regs
    import ctrl_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAIN_MIN    = -81,
    parameter int CLAMP_MAX   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n,
    input  logic               sclk,
    input  logic               sdin,
    output logic [GAIN_W-1:0]  gain_code,
    output logic               standby,
    output logic               smp_inv,
    output logic               ob_inv,
    output logic               lowclk_mode,
    output logic               ofs_en,
    output logic [OFS_W-1:0]   ofs_code,
    output logic [CLAMP_W-1:0] clamp_code,
    output logic               out_linv,
    output logic               out_minv,
    output logic               out_test,
    output logic               core_run,
    output logic               ofs_cal,
    output logic               sleep,
    output logic               wr_pulse,
    output logic [ADDR_W-1:0]  wr_addr
);
    logic [2:0]         pins_s;
    logic               frame_ok;
    logic [FRAME_W-1:0] frame;
    ctl_fields_t        ctl;

    ctrl_pin_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, sclk, sdin}),
        .q     (pins_s)
    );

    ctrl_frame_rx #(
        .FRAME_W (FRAME_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (pins_s[2]),
        .sck      (pins_s[1]),
        .sd       (pins_s[0]),
        .frame_ok (frame_ok),
        .frame    (frame)
    );

    ctrl_reg_bank #(
        .GAIN_MIN  (GAIN_MIN),
        .CLAMP_MAX (CLAMP_MAX)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_ok  (frame_ok),
        .frame     (frame),
        .gain_out  (gain_code),
        .stby_out  (standby),
        .ctl_out   (ctl),
        .clamp_out (clamp_code),
        .pulse_out (wr_pulse),
        .addr_out  (wr_addr)
    );

    assign smp_inv     = ctl.smp_inv;
    assign ob_inv      = ctl.ob_inv;
    assign lowclk_mode = ctl.lowclk;
    assign ofs_en      = ctl.ofs_en;
    assign ofs_code    = ctl.ofs_code;
    assign out_linv    = ctl.linv;
    assign out_minv    = ctl.minv;
    assign out_test    = ctl.test;
    assign core_run    = ctl.run;
    assign ofs_cal     = ctl.ofs_cal;
    assign sleep       = ctl.sleep;
endmodule

// File: rtl/ctrl_serial_regs_chk.sv
module ctrl_serial_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_n,
    input logic [10:0] gain_code,
    input logic        standby,
    input logic        smp_inv,
    input logic        ob_inv,
    input logic        lowclk_mode,
    input logic        ofs_en,
    input logic [3:0]  ofs_code,
    input logic [4:0]  clamp_code,
    input logic        out_linv,
    input logic        out_minv,
    input logic        out_test,
    input logic        core_run,
    input logic        ofs_cal,
    input logic        sleep,
    input logic        wr_pulse,
    input logic [1:0]  wr_addr
);
    localparam logic signed [10:0] GAIN_LIM = -11'sd81;

    logic [13:0] ctl_vec;
    logic [31:0] all_vec;
    assign ctl_vec = {sleep, ofs_cal, core_run, out_test, out_minv, out_linv,
                      ofs_code, ofs_en, lowclk_mode, ob_inv, smp_inv};
    assign all_vec = {standby, gain_code, ctl_vec, clamp_code, 1'b0};

    p_gain_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(gain_code) >= GAIN_LIM);

    p_clamp_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_code <= 5'd24);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    p_pulse_after_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> sel_n);

    p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |-> $stable(all_vec));

    p_gain_write_scope_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_addr == 2'd0) |-> $stable({ctl_vec, clamp_code}));

    p_test_addr_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_addr == 2'd3) |-> $stable(all_vec));
endmodule

bind ctrl_serial_regs ctrl_serial_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .gain_code   (gain_code),
    .standby     (standby),
    .smp_inv     (smp_inv),
    .ob_inv      (ob_inv),
    .lowclk_mode (lowclk_mode),
    .ofs_en      (ofs_en),
    .ofs_code    (ofs_code),
    .clamp_code  (clamp_code),
    .out_linv    (out_linv),
    .out_minv    (out_minv),
    .out_test    (out_test),
    .core_run    (core_run),
    .ofs_cal     (ofs_cal),
    .sleep       (sleep),
    .wr_pulse    (wr_pulse),
    .wr_addr     (wr_addr)
);

// File: tb/ctrl_serial_regs_test.sv
module ctrl_serial_regs_test;
    logic clk = 1'b0;
    logic rst_n, sel_n, sclk, sdin;
    logic [10:0] gain_code;
    logic standby, smp_inv, ob_inv, lowclk_mode, ofs_en;
    logic [3:0] ofs_code;
    logic [4:0] clamp_code;
    logic out_linv, out_minv, out_test, core_run, ofs_cal, sleep, wr_pulse;
    logic [1:0] wr_addr;

    int n_chk = 0;
    int n_err = 0;
    int n_pulse = 0;
    int run_len = 0;
    int max_run = 0;
    int exp_pulse = 0;
    logic [1:0] last_addr = 2'd0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctrl_serial_regs uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
        .gain_code(gain_code), .standby(standby), .smp_inv(smp_inv),
        .ob_inv(ob_inv), .lowclk_mode(lowclk_mode), .ofs_en(ofs_en),
        .ofs_code(ofs_code), .clamp_code(clamp_code), .out_linv(out_linv),
        .out_minv(out_minv), .out_test(out_test), .core_run(core_run),
        .ofs_cal(ofs_cal), .sleep(sleep), .wr_pulse(wr_pulse), .wr_addr(wr_addr)
    );

    // {frame, expected gain, expected clamp}
    localparam int NV = 11;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0014, 11'h005, 5'd0},
        {16'h002A, 11'h005, 5'd10},
        {16'h0FFC, 11'h3FF, 5'd10},
        {16'h1EBC, 11'h7AF, 5'd10},
        {16'h1EB8, 11'h7AF, 5'd10},
        {16'h1000, 11'h7AF, 5'd10},
        {16'h0062, 11'h7AF, 5'd24},
        {16'h007E, 11'h7AF, 5'd24},
        {16'h1FFC, 11'h7FF, 5'd24},
        {16'hFFFF, 11'h7FF, 5'd24},
        {16'hFF82, 11'h7FF, 5'd0}
    };

    always @(negedge clk) begin
        if (wr_pulse) begin
            n_pulse++;
            run_len++;
            last_addr = wr_addr;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        sel_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic shift_bits(input logic [15:0] f, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdin = f[i % 16];
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
        end
        sclk = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_high();
        sel_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic send(input logic [15:0] f, input int nbits);
        cs_low();
        shift_bits(f, nbits);
        cs_high();
    endtask

    function automatic logic [13:0] ctl_obs();
        return {sleep, ofs_cal, core_run, out_test, out_minv, out_linv,
                ofs_code, ofs_en, lowclk_mode, ob_inv, smp_inv};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdin = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R9: reset values
        chk("R9 reset fields", {standby, gain_code, ctl_obs(), clamp_code, wr_pulse},
            32'h0);

        // R1 R2 R6 R8: table of frames
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][31:16], 16);
            exp_pulse++;
            chk($sformatf("R6 R1 gain vec %0d", v), 32'(gain_code), 32'(VEC[v][15:5]));
            chk($sformatf("R8 clamp vec %0d", v), 32'(clamp_code), 32'(VEC[v][4:0]));
            chk($sformatf("R10 addr vec %0d", v), 32'(last_addr), 32'(VEC[v][17:16]));
        end
        // R2: addr 3 and gain/clamp writes left control and standby untouched
        chk("R2 ctrl untouched", {18'h0, ctl_obs()}, 32'h0);
        chk("R2 standby untouched", 32'(standby), 32'h0);

        // R7: control field positions
        send(16'hB6B5, 16);
        exp_pulse++;
        chk("R7 control fields", {18'h0, ctl_obs()}, {18'h0, 14'b1_0_1_1_0_1_1010_1_1_0_1});
        chk("R2 ctrl write keeps gain", 32'(gain_code), 32'h7FF);

        // R11: standby through gain write
        send(16'h801C, 16);
        exp_pulse++;
        chk("R11 standby", 32'(standby), 32'h1);
        chk("R11 gain", 32'(gain_code), 32'h007);
        chk("R2 gain write keeps ctrl", {18'h0, ctl_obs()}, {18'h0, 14'b1_0_1_1_0_1_1010_1_1_0_1});

        // R5: no update before select rises
        cs_low();
        shift_bits(16'h0FFC, 16);
        wait_clk(8);
        chk("R5 gain before commit", 32'(gain_code), 32'h007);
        chk("R5 standby before commit", 32'(standby), 32'h1);
        cs_high();
        exp_pulse++;
        chk("R5 gain after commit", 32'(gain_code), 32'h3FF);

        // R3: short frame
        send(16'h0014, 15);
        chk("R3 short frame gain", 32'(gain_code), 32'h3FF);
        // R4: long frame
        send(16'h0014, 17);
        chk("R4 long frame gain", 32'(gain_code), 32'h3FF);

        // R10: pulse bookkeeping
        chk("R10 pulse count", 32'(n_pulse), 32'(exp_pulse));
        chk("R10 pulse width", 32'(max_run), 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule